// File: doc/BRIEF.md
# I2C line-to-transaction bridge

This block sits on the target side of a two-wire serial bus that a bit-banging controller drives. It watches the clock and data levels, recognises start and stop conditions, and assembles the serial bits into bytes. It then forwards each byte as a request on a simple request/response bus toward a single downstream target. The first byte after a start is sent as an address request. Later bytes become write requests, or, when the address byte asked for a read, byte-fetch requests. The target's ack, nack and read data are relayed back to the controller bit by bit on the data line.

Both line inputs pass through a synchronizer and are compared against stored copies of the previous levels, all in one clock domain. The block returns one data level to the controller. That level is the device's own drive ANDed with the controller's level, which models the open-drain wire. While a downstream request is outstanding, the bridge defers line events, so no edge is lost. The controller is expected to clock the bus slowly enough that the target answers within one clock high phase.

Top module: `i2c_txn_bridge`

## Requirements
- R1: After reset, sda_o is 1, req_valid_o is 0 and the bridge is idle with no address held.
- R2: A falling data level while the clock is high is a start: it drops any held address, and the next eight clocked bits form a new address byte, including after a repeated start that has no stop before it.
- R3: A rising data level while the clock is high is a stop: if an address is held, an end request (op code 3) is issued once; the address is dropped and the bridge goes idle. A stop with no held address issues nothing.
- R4: Data level changes while the clock is low issue no request and change no protocol state.
- R5: Data bits are sampled on each rising clock, most significant bit first. The ninth rising clock of a byte is the ack slot.
- R6: In the ack slot, the first byte after a start is issued as an address request (op code 0) carrying the whole byte: bits 7:1 are the target address and bit 0 is the read flag. Each later byte is issued as a write request (op code 1) carrying the byte.
- R7: When the target acks, sda_o is 0 during the high phase of the ack clock. On every falling clock edge the device drive returns to 1.
- R8: When the target nacks an address or a write, the bridge issues an end request (op code 3), drops the address, keeps sda_o at 1 in the ack slot, and ignores further clocks until the next start.
- R9: After an acked address with bit 0 = 1, the first rising clock issues a read request (op code 2). The returned byte is presented on sda_o, most significant bit first, over eight rising clocks.
- R10: In the controller's ack slot after a read byte, data 0 starts another read request. Data 1 issues a nack notice (op code 4), and the device then keeps its drive at 1 until the next start; the address stays held, so a later stop still issues an end request.
- R11: sda_o equals the device drive ANDed with the synchronized controller data level.
- R12: A request holds req_op_o and req_data_o stable until req_ready_i accepts it. Line events that occur while a request or response is pending are processed after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the controller |
| sda_i | input | 1 | Serial data level from the controller |
| sda_o | output | 1 | Resulting data wire level (device AND controller) |
| req_valid_o | output | 1 | Downstream request valid |
| req_ready_i | input | 1 | Downstream request accepted |
| req_op_o | output | 3 | Request code: 0 address, 1 write, 2 read, 3 end, 4 nack notice |
| req_data_o | output | 8 | Address byte or write byte |
| rsp_valid_i | input | 1 | Response for address, write or read request |
| rsp_nack_i | input | 1 | Target nacked the address or write |
| rsp_data_i | input | 8 | Byte returned for a read request |

## Verification
A wrong bit count or a wrong phase shows up at the ports on the next ack slot. The data wire either fails to go low, or goes low during a data bit, within nine serial clocks. A wrong address flag or a lost held address shows up on the downstream bus as a wrong op code: a write in place of a read, or a missing or extra end request, at the next byte or stop. Read serialization faults show up as wrong bits on sda_o in the same high phase in which they occur, and a stuck device drive shows up as a 0 seen after a falling clock.

// File: rtl/i2c_txn_bridge_pkg.sv
package i2c_txn_bridge_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADDR = 3'd0,
    OP_WR   = 3'd1,
    OP_RD   = 3'd2,
    OP_END  = 3'd3,
    OP_NACK = 3'd4
  } dn_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TX,
    PH_WACK,
    PH_RX,
    PH_MACK,
    PH_NACKED
  } phase_e;

  function automatic logic op_needs_rsp(dn_op_e op);
    return (op == OP_ADDR) || (op == OP_WR) || (op == OP_RD);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '1;
      else         sr_q <= {sr_q[STAGES-2:0], line_i[g]};
    end
    assign line_o[g] = sr_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_dn_port.sv
module i2c_dn_port
  import i2c_txn_bridge_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  dn_op_e            op_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [OP_W-1:0]   req_op_o,
  output logic [BYTE_W-1:0] req_data_o,
  input  logic              rsp_valid_i
);

  typedef enum logic [1:0] {DN_IDLE, DN_REQ, DN_WAIT} dn_st_e;

  dn_st_e            st_q;
  dn_op_e            op_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DN_IDLE;
      op_q   <= OP_END;
      data_q <= '0;
    end else if (issue_i) begin
      st_q   <= DN_REQ;
      op_q   <= op_i;
      data_q <= data_i;
    end else begin
      unique case (st_q)
        DN_REQ:  if (req_ready_i) st_q <= op_needs_rsp(op_q) ? DN_WAIT : DN_IDLE;
        DN_WAIT: if (rsp_valid_i) st_q <= DN_IDLE;
        default: st_q <= DN_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != DN_IDLE);
  assign done_o      = (st_q == DN_WAIT) && rsp_valid_i;
  assign req_valid_o = (st_q == DN_REQ);
  assign req_op_o    = op_q;
  assign req_data_o  = data_q;

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_op_o) && $stable(req_data_o)));

  a_r12_no_issue_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (st_q != DN_REQ));

endmodule

// File: rtl/i2c_bridge_ctrl.sv
module i2c_bridge_ctrl
  import i2c_txn_bridge_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              rsp_nack_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  output logic              issue_o,
  output dn_op_e            op_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              sda_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              l_scl_q, l_scl_d, l_sda_q, l_sda_d, dev_q, dev_d;
  logic              vld_q, vld_d;
  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] buf_q, buf_d, addr_q, addr_d;

  always_comb begin
    l_scl_d = l_scl_q;
    l_sda_d = l_sda_q;
    dev_d   = dev_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    buf_d   = buf_q;
    addr_d  = addr_q;
    vld_d   = vld_q;
    issue_o = 1'b0;
    op_o    = OP_END;
    data_o  = '0;
    if (done_i) begin
      if (ph_q == PH_WACK) begin
        if (rsp_nack_i) begin
          issue_o = 1'b1;
          op_o    = OP_END;
          data_o  = addr_q;
          vld_d   = 1'b0;
          ph_d    = PH_IDLE;
          dev_d   = 1'b1;
        end else begin
          dev_d = 1'b0;
          cnt_d = '0;
          ph_d  = addr_q[0] ? PH_RX : PH_TX;
        end
      end else if (ph_q == PH_RX) begin
        dev_d = rsp_data_i[BYTE_W-1];
        buf_d = {rsp_data_i[BYTE_W-2:0], 1'b0};
        cnt_d = CNT_W'(1);
      end
    end else if (!busy_i) begin
      if (sda_i != l_sda_q) begin
        l_sda_d = sda_i;
        if (l_scl_q) begin
          dev_d = 1'b1;
          if (!sda_i) begin
            ph_d  = PH_TX;
            cnt_d = '0;
            vld_d = 1'b0;
          end else begin
            if (vld_q) begin
              issue_o = 1'b1;
              op_o    = OP_END;
              data_o  = addr_q;
            end
            vld_d = 1'b0;
            ph_d  = PH_IDLE;
          end
        end
      end else if (scl_i != l_scl_q) begin
        l_scl_d = scl_i;
        if (!scl_i) begin
          dev_d = 1'b1;
        end else begin
          unique case (ph_q)
            PH_TX: begin
              dev_d = 1'b1;
              buf_d = {buf_q[BYTE_W-2:0], l_sda_q};
              if (cnt_q == LAST) begin
                ph_d  = PH_WACK;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            PH_WACK: begin
              issue_o = 1'b1;
              data_o  = buf_q;
              if (!vld_q) begin
                op_o   = OP_ADDR;
                addr_d = buf_q;
                vld_d  = 1'b1;
              end else begin
                op_o = OP_WR;
              end
            end
            PH_RX: begin
              if (cnt_q == '0) begin
                issue_o = 1'b1;
                op_o    = OP_RD;
              end else begin
                dev_d = buf_q[BYTE_W-1];
                buf_d = {buf_q[BYTE_W-2:0], 1'b0};
                if (cnt_q == LAST) begin
                  ph_d  = PH_MACK;
                  cnt_d = '0;
                end else begin
                  cnt_d = cnt_q + 1'b1;
                end
              end
            end
            PH_MACK: begin
              dev_d = 1'b1;
              if (!l_sda_q) begin
                ph_d  = PH_RX;
                cnt_d = '0;
              end else begin
                ph_d    = PH_NACKED;
                issue_o = 1'b1;
                op_o    = OP_NACK;
              end
            end
            default: dev_d = 1'b1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_scl_q <= 1'b1;
      l_sda_q <= 1'b1;
      dev_q   <= 1'b1;
      vld_q   <= 1'b0;
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      buf_q   <= '0;
      addr_q  <= '0;
    end else begin
      l_scl_q <= l_scl_d;
      l_sda_q <= l_sda_d;
      dev_q   <= dev_d;
      vld_q   <= vld_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      buf_q   <= buf_d;
      addr_q  <= addr_d;
    end
  end

  assign sda_o = dev_q & l_sda_q;

  a_r7_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(l_scl_q) |-> dev_q);

  a_r10_nacked_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_NACKED) |-> dev_q);

  a_r12_defer_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(l_scl_q) && $stable(l_sda_q)));

  a_r6_write_has_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && op_o == OP_WR) |-> vld_q);

  a_r4_low_clock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sda_i != l_sda_q) && !l_scl_q && !busy_i && !done_i) |-> !issue_o);

endmodule

// File: rtl/i2c_txn_bridge.sv
module i2c_txn_bridge
  import i2c_txn_bridge_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [OP_W-1:0]   req_op_o,
  output logic [BYTE_W-1:0] req_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_nack_i,
  input  logic [BYTE_W-1:0] rsp_data_i
);

  logic [1:0]        lines_s;
  logic              busy, done, issue;
  dn_op_e            op;
  logic [BYTE_W-1:0] data;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .line_o (lines_s)
  );

  i2c_bridge_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (lines_s[1]),
    .sda_i      (lines_s[0]),
    .busy_i     (busy),
    .done_i     (done),
    .rsp_nack_i (rsp_nack_i),
    .rsp_data_i (rsp_data_i),
    .issue_o    (issue),
    .op_o       (op),
    .data_o     (data),
    .sda_o      (sda_o)
  );

  i2c_dn_port #(.BYTE_W(BYTE_W)) u_dn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .op_i        (op),
    .data_i      (data),
    .busy_o      (busy),
    .done_o      (done),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_op_o    (req_op_o),
    .req_data_o  (req_data_o),
    .rsp_valid_i (rsp_valid_i)
  );

endmodule

// File: tb/i2c_txn_bridge_tb.sv
module i2c_txn_bridge_tb;

  localparam int HP = 20;
  localparam logic [6:0] TGT = 7'h3A;
  localparam int LOGN = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic sda_o, req_valid_o, req_ready_i = 1'b0;
  logic [2:0] req_op_o;
  logic [7:0] req_data_o;
  logic rsp_valid_i = 1'b0, rsp_nack_i = 1'b0;
  logic [7:0] rsp_data_i = 8'h00;

  always #10 clk = ~clk;

  i2c_txn_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_op_o(req_op_o),
    .req_data_o(req_data_o), .rsp_valid_i(rsp_valid_i), .rsp_nack_i(rsp_nack_i),
    .rsp_data_i(rsp_data_i)
  );

  int n_chk = 0, n_err = 0;
  int hold_bad = 0;
  logic [2:0] dn_op [LOGN];
  logic [7:0] dn_dat[LOGN];
  int n_dn = 0;
  logic [7:0] rd_val;
  logic [2:0] ex_op [LOGN];
  logic [7:0] ex_dat[LOGN];
  int n_ex = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // downstream target model
  initial begin
    logic [2:0] c_op;
    logic [7:0] c_d;
    forever begin
      @(negedge clk);
      if (rst_ni && req_valid_o) begin
        c_op = req_op_o;
        c_d  = req_data_o;
        if ($urandom_range(0, 1) == 1) @(negedge clk);
        if (!req_valid_o || req_op_o != c_op || req_data_o != c_d) hold_bad++;
        req_ready_i = 1'b1;
        @(negedge clk);
        req_ready_i = 1'b0;
        if (n_dn < LOGN) begin
          dn_op[n_dn]  = c_op;
          dn_dat[n_dn] = c_d;
        end
        n_dn++;
        if (c_op <= 3'd2) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          rsp_nack_i = 1'b0;
          if (c_op == 3'd0) rsp_nack_i = (c_d[7:1] != TGT);
          if (c_op == 3'd1) rsp_nack_i = (c_d == 8'hFF);
          if (c_op == 3'd2) begin
            rd_val     = 8'($urandom_range(0, 255));
            rsp_data_i = rd_val;
          end
          rsp_valid_i = 1'b1;
          @(negedge clk);
          rsp_valid_i = 1'b0;
        end
      end
    end
  end

  function automatic bit exp_addr_nack(input logic [7:0] a);
    return a[7:1] != TGT;
  endfunction

  function automatic bit exp_wr_nack(input logic [7:0] d);
    return d == 8'hFF;
  endfunction

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic expect_req(input logic [2:0] op, input logic [7:0] d);
    if (n_ex < LOGN) begin
      ex_op[n_ex]  = op;
      ex_dat[n_ex] = d;
    end
    n_ex++;
  endtask

  task automatic clear_log();
    n_dn = 0;
    n_ex = 0;
  endtask

  task automatic check_log(input string req);
    repeat (8) @(negedge clk);
    chk(n_dn == n_ex, req, "request count", n_dn, n_ex);
    for (int i = 0; i < n_ex && i < n_dn && i < LOGN; i++) begin
      chk(dn_op[i] == ex_op[i], req, "request op", dn_op[i], ex_op[i]);
      if (ex_op[i] <= 3'd1)
        chk(dn_dat[i] == ex_dat[i], req, "request data", dn_dat[i], ex_dat[i]);
    end
  endtask

  task automatic m_clock(input bit b, output bit seen, output bit rel);
    sda_i = b;
    half();
    scl_i = 1'b1;
    repeat (HP - 2) @(negedge clk);
    seen = sda_o;
    repeat (2) @(negedge clk);
    scl_i = 1'b0;
    repeat (6) @(negedge clk);
    rel = sda_o;
    repeat (HP - 6) @(negedge clk);
  endtask

  task automatic m_start();
    sda_i = 1'b1; half();
    scl_i = 1'b1; half();
    sda_i = 1'b0; half();
    scl_i = 1'b0; half();
  endtask

  task automatic m_stop();
    sda_i = 1'b0; half();
    scl_i = 1'b1; half();
    sda_i = 1'b1; half();
  endtask

  task automatic m_write(input logic [7:0] d, output bit ack, output bit rel);
    bit s, r;
    for (int i = 7; i >= 0; i--) m_clock(d[i], s, r);
    m_clock(1'b1, ack, rel);
  endtask

  task automatic m_read(input bit mack, output logic [7:0] got);
    bit s, r;
    for (int i = 7; i >= 0; i--) begin
      m_clock(1'b1, s, r);
      got[i] = s;
    end
    m_clock(mack, s, r);
  endtask

  initial begin
    bit ack, rel;
    logic [7:0] got, a, d;
    int nb;
    void'($urandom(32'h1C2B));
    repeat (3) @(negedge clk);
    chk(sda_o == 1'b1, "R1", "sda_o in reset", sda_o, 1);
    chk(req_valid_o == 1'b0, "R1", "req_valid_o in reset", req_valid_o, 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk(sda_o == 1'b1 && req_valid_o == 1'b0, "R1", "idle after reset", {sda_o, req_valid_o}, 2);

    // R4 / R11: data toggles while clock low
    clear_log();
    scl_i = 1'b0; half();
    sda_i = 1'b0; repeat (6) @(negedge clk);
    chk(sda_o == 1'b0, "R11", "wire follows controller low", sda_o, 0);
    sda_i = 1'b1; repeat (6) @(negedge clk);
    chk(sda_o == 1'b1, "R11", "wire follows controller high", sda_o, 1);
    sda_i = 1'b0; half();
    scl_i = 1'b1; half();
    sda_i = 1'b1; half();
    check_log("R4");
    chk(req_valid_o == 1'b0, "R4", "no request pending", req_valid_o, 0);

    // R5 R6 R7: write transaction
    clear_log();
    m_start();
    m_write({TGT, 1'b0}, ack, rel);
    chk(ack == 1'b0, "R7", "address ack low", ack, 0);
    chk(rel == 1'b1, "R7", "released after ack clock", rel, 1);
    expect_req(3'd0, {TGT, 1'b0});
    m_write(8'h5A, ack, rel);
    chk(ack == 1'b0, "R7", "write ack 5A", ack, 0);
    expect_req(3'd1, 8'h5A);
    m_write(8'hC3, ack, rel);
    chk(ack == 1'b0 && rel == 1'b1, "R7", "write ack C3 and release", {ack, rel}, 1);
    expect_req(3'd1, 8'hC3);
    m_stop();
    expect_req(3'd3, 8'h00);
    check_log("R6");

    // R8: address nack
    clear_log();
    m_start();
    m_write({7'h11, 1'b0}, ack, rel);
    chk(ack == 1'b1, "R8", "address nack", ack, 1);
    expect_req(3'd0, {7'h11, 1'b0});
    expect_req(3'd3, 8'h00);
    m_write(8'h00, ack, rel);
    chk(ack == 1'b1, "R8", "clocks ignored after nack", ack, 1);
    m_stop();
    check_log("R8");

    // R8: write nack
    clear_log();
    m_start();
    m_write({TGT, 1'b0}, ack, rel);
    expect_req(3'd0, {TGT, 1'b0});
    m_write(8'hFF, ack, rel);
    chk(ack == 1'b1, "R8", "write nack", ack, 1);
    expect_req(3'd1, 8'hFF);
    expect_req(3'd3, 8'h00);
    m_stop();
    check_log("R8");

    // R9 R10: read transaction
    clear_log();
    m_start();
    m_write({TGT, 1'b1}, ack, rel);
    chk(ack == 1'b0, "R9", "read address ack", ack, 0);
    expect_req(3'd0, {TGT, 1'b1});
    for (int k = 0; k < 3; k++) begin
      m_read(k == 2, got);
      chk(got == rd_val, "R9", "read byte", got, rd_val);
      expect_req(3'd2, 8'h00);
    end
    expect_req(3'd4, 8'h00);
    m_read(1'b1, got);
    chk(got == 8'hFF, "R10", "released after controller nack", got, 8'hFF);
    m_stop();
    expect_req(3'd3, 8'h00);
    check_log("R10");

    // R2: repeated start
    clear_log();
    m_start();
    m_write({TGT, 1'b0}, ack, rel);
    expect_req(3'd0, {TGT, 1'b0});
    m_write(8'h12, ack, rel);
    expect_req(3'd1, 8'h12);
    m_start();
    m_write({TGT, 1'b1}, ack, rel);
    chk(ack == 1'b0, "R2", "repeated start address ack", ack, 0);
    expect_req(3'd0, {TGT, 1'b1});
    m_read(1'b1, got);
    chk(got == rd_val, "R2", "read after repeated start", got, rd_val);
    expect_req(3'd2, 8'h00);
    expect_req(3'd4, 8'h00);
    m_stop();
    expect_req(3'd3, 8'h00);
    check_log("R2");

    // R3: stop with no address
    clear_log();
    m_start();
    m_stop();
    check_log("R3");

    // random transactions
    for (int t = 0; t < 24; t++) begin
      clear_log();
      a[7:1] = ($urandom_range(0, 3) != 0) ? TGT : 7'($urandom_range(0, 127));
      a[0]   = 1'($urandom_range(0, 1));
      nb     = $urandom_range(1, 3);
      m_start();
      m_write(a, ack, rel);
      chk(ack == exp_addr_nack(a), "R6", "random address response", ack, exp_addr_nack(a));
      expect_req(3'd0, a);
      if (exp_addr_nack(a)) begin
        expect_req(3'd3, 8'h00);
      end else if (!a[0]) begin
        for (int k = 0; k < nb; k++) begin
          d = 8'($urandom_range(0, 255));
          m_write(d, ack, rel);
          chk(ack == exp_wr_nack(d), "R5", "random write response", ack, exp_wr_nack(d));
          expect_req(3'd1, d);
          if (exp_wr_nack(d)) begin
            expect_req(3'd3, 8'h00);
            break;
          end
          if (k == nb - 1) expect_req(3'd3, 8'h00);
        end
      end else begin
        for (int k = 0; k < nb; k++) begin
          m_read(k == nb - 1, got);
          chk(got == rd_val, "R9", "random read byte", got, rd_val);
          expect_req(3'd2, 8'h00);
        end
        expect_req(3'd4, 8'h00);
        expect_req(3'd3, 8'h00);
      end
      m_stop();
      check_log("R12");
    end

    chk(hold_bad == 0, "R12", "request held until accepted", hold_bad, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(negedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule